// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station-management master. Software sets it up and launches transfers through four 32-bit registers: configuration/status, control, data and address. The block then shifts Clause 22 or Clause 45 management frames out to external PHYs. The management clock MDC is derived from the system clock through a programmable divider. The bidirectional MDIO line appears as three signals: a driven value, an output enable and a sampled input. An external pad joins them and supplies the pull-up.

A frame is launched as a side effect of a register write:
- A data-register write sends a write frame.
- A control-register write with the read bit set sends a read frame.
- In Clause 45 mode, an address-register write sends an address frame.

Two busy flags track completion. The status flag covers the address phase and the data-register flag covers the read or write. Software polls them before it issues the next access. A read that finds no PHY driving the second turnaround bit low sets a read-error flag, and the data register then returns all ones.

A frame engine sequences each transfer through the states ST_IDLE, ST_PREAMBLE, ST_HEADER, ST_TURN, ST_PAYLOAD and ST_FINISH. The transitions are:
- ST_IDLE moves to ST_PREAMBLE on a start, or to ST_HEADER if preamble is disabled.
- ST_PREAMBLE moves to ST_HEADER after its 32nd bit.
- ST_HEADER moves to ST_TURN after the 14 start, opcode and address bits.
- ST_TURN moves to ST_PAYLOAD after the two turnaround bits.
- ST_PAYLOAD moves to ST_FINISH after 16 data bits.
- ST_FINISH returns to ST_IDLE after one cycle, clearing the busy flags and storing any read result.

The engine's bit counter advances on MDC rising edges.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, all four registers (index 0 config/status, 1 control, 2 data, 3 address) read as zero, MDC is high and the MDIO output enable is low. Whenever no busy flag is set, MDC stays high and the enable stays low.
- R2: Config bits 15:8 hold a value D. MDC runs with a period of 2*D system clocks while a frame is active, and D = 0 gives a period of 2 clocks.
- R3: A data-register write in Clause 22 mode (config bit 6 = 0) sends the frame MSB first, in this order:
  - 32 driven ones;
  - start 01 and opcode 01;
  - port address (control bits 9:5) and register address (control bits 4:0);
  - turnaround 10;
  - data bits 15:0.
- R4: In Clause 45 mode (config bit 6 = 1), an address-register write sends start 00, opcode 00, port, device, turnaround 10 and the 16-bit address, with status bit 0 set until the frame ends. In Clause 22 mode the same write only stores the value and sends nothing.
- R5: Clause 45 data transfers use start 00, with opcode 01 for a write and 11 for a read.
- R6: A control write with bit 15 set sends a read frame, with opcode 10 in Clause 22 mode. The master drives only the 14 start, opcode and address bits and releases MDIO for the turnaround and the 16 data bits. The 16 bits sampled on MDC rising edges land in data bits 15:0.
- R7: If MDIO is high when sampled in the second turnaround bit of a read, status bit 1 is set and data bits 15:0 read 0xFFFF. The flag clears when the next frame starts.
- R8: Control bit 10 set removes the 32-bit preamble, so the frame is exactly 32 MDC cycles.
- R9: Data bit 31 reads 1 from the write that starts a read or write frame until that frame has ended. MDC toggles only while a busy flag is set.
- R10: Any register write made while either busy flag is set is discarded. It changes no register and starts no frame.
- R11: The MDIO output value changes only on MDC falling edges.
- R12: Control bit 15 always reads back as 0. A control write with bit 15 clear only stores the address and preamble fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 config/status, 1 control, 2 data, 3 address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | High when the master drives MDIO |
| mdio_in | input | 1 | Sampled MDIO line |

## Verification
A corrupted state or bit counter shows up as a frame of the wrong length or with bits out of place. The bench's PHY model sees this on the very next transfer, because it records the line at every MDC rise and compares it against a frame built from the requirements. A busy flag that clears early or stays stuck shows up within one poll as a wrong data-register bit 31 or status bit 0, or as MDC toggling while idle. A missed turnaround sample shows up at the end of the read as a wrong error flag or a data word that is not 0xFFFF. Random transfers in both clause modes with random divider values, preamble settings and PHY presence are mixed with directed cases for divider zero, a missing PHY, an address write in Clause 22 mode and writes made while busy.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } xfer_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_HEADER   = 3'd2,
        ST_TURN     = 3'd3,
        ST_PAYLOAD  = 3'd4,
        ST_FINISH   = 3'd5
    } eng_state_e;

    localparam logic [1:0] REG_CFG  = 2'd0;
    localparam logic [1:0] REG_CTL  = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_ADDR = 2'd3;

    // 32-bit management frame, MSB goes out first
    function automatic logic [31:0] build_frame(
        input logic        c45,
        input xfer_kind_e  kind,
        input logic [4:0]  port,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        logic [1:0] st;
        logic [1:0] op;
        st = c45 ? 2'b00 : 2'b01;
        case (kind)
            OP_ADDR:  op = 2'b00;
            OP_WRITE: op = 2'b01;
            OP_READ:  op = c45 ? 2'b11 : 2'b10;
            default:  op = 2'b00;
        endcase
        return {st, op, port, dev, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    always_comb begin
        limit    = (half == '0) ? '0 : half - 1'b1;
        tick     = run && (cnt == limit);
        fall_stb = tick && mdc;
        rise_stb = tick && !mdc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b1;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  xfer_kind_e       kind,
    input  logic             pre_off,
    input  logic [31:0]      frame,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             rd_fail
);

    localparam int CNT_W = (PRE_BITS > 32) ? $clog2(PRE_BITS) : 5;
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(13);
    localparam logic [CNT_W-1:0] TA_LAST  = CNT_W'(15);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(31);

    eng_state_e       state, state_d;
    logic [CNT_W-1:0] bit_cnt, cnt_d;
    logic [31:0]      frm_q;
    logic             is_rd;
    logic [15:0]      shreg;
    logic             fail;
    logic             run;
    logic             rise, fall;
    logic [4:0]       fidx;

    assign run  = (state == ST_PREAMBLE) || (state == ST_HEADER) ||
                  (state == ST_TURN) || (state == ST_PAYLOAD);
    assign fidx = 5'd31 - bit_cnt[4:0];

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half     (half),
        .mdc      (mdc),
        .rise_stb (rise),
        .fall_stb (fall)
    );

    // next-state logic: bit counter advances on MDC rising edges
    always_comb begin
        state_d = state;
        cnt_d   = bit_cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_d = pre_off ? ST_HEADER : ST_PREAMBLE;
                    cnt_d   = '0;
                end
            end
            ST_PREAMBLE: begin
                if (rise) begin
                    if (bit_cnt == PRE_LAST) begin
                        state_d = ST_HEADER;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = bit_cnt + 1'b1;
                    end
                end
            end
            ST_HEADER: begin
                if (rise) begin
                    if (bit_cnt == HDR_LAST) state_d = ST_TURN;
                    cnt_d = bit_cnt + 1'b1;
                end
            end
            ST_TURN: begin
                if (rise) begin
                    if (bit_cnt == TA_LAST) state_d = ST_PAYLOAD;
                    cnt_d = bit_cnt + 1'b1;
                end
            end
            ST_PAYLOAD: begin
                if (rise) begin
                    if (bit_cnt == DAT_LAST) begin
                        state_d = ST_FINISH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = bit_cnt + 1'b1;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state   <= state_d;
            bit_cnt <= cnt_d;
        end
    end

    // outputs: drive on MDC fall, sample on MDC rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            frm_q    <= '0;
            is_rd    <= 1'b0;
            shreg    <= '0;
            fail     <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                frm_q <= frame;
                is_rd <= (kind == OP_READ);
                fail  <= 1'b0;
            end
            if (fall) begin
                unique case (state)
                    ST_PREAMBLE: begin
                        mdio_out <= 1'b1;
                        mdio_oe  <= 1'b1;
                    end
                    ST_HEADER: begin
                        mdio_out <= frm_q[fidx];
                        mdio_oe  <= 1'b1;
                    end
                    ST_TURN, ST_PAYLOAD: begin
                        mdio_out <= frm_q[fidx];
                        mdio_oe  <= !is_rd;
                    end
                    default: ;
                endcase
            end
            if (rise && is_rd) begin
                if (state == ST_TURN && bit_cnt == TA_LAST) fail <= mdio_in;
                if (state == ST_PAYLOAD) shreg <= {shreg[14:0], mdio_in};
            end
            if (state == ST_FINISH) mdio_oe <= 1'b0;
        end
    end

    assign done    = (state == ST_FINISH);
    assign rd_data = fail ? 16'hFFFF : shreg;
    assign rd_fail = fail;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    logic             mode_c45;
    logic [DIV_W-1:0] div_q;
    logic             addr_busy, data_busy, rd_pend, rd_err;
    logic [4:0]       ctl_dev, ctl_port;
    logic             ctl_pre_off;
    logic [15:0]      data_q, addr_q;
    logic             busy_any;

    logic             start;
    xfer_kind_e       kind;
    logic [4:0]       f_port, f_dev;
    logic             f_pre_off;
    logic [15:0]      payload;
    logic [31:0]      frame;

    logic             eng_done;
    logic [15:0]      eng_rdata;
    logic             eng_fail;
    logic             unused_wbits;

    assign busy_any     = addr_busy || data_busy;
    assign unused_wbits = ^reg_wdata[31:16];

    // decode the write that launches a frame
    always_comb begin
        start     = 1'b0;
        kind      = OP_WRITE;
        f_port    = ctl_port;
        f_dev     = ctl_dev;
        f_pre_off = ctl_pre_off;
        payload   = reg_wdata[15:0];
        if (reg_wr_en && !busy_any) begin
            case (reg_addr)
                REG_CTL: begin
                    if (reg_wdata[15]) begin
                        start     = 1'b1;
                        kind      = OP_READ;
                        f_port    = reg_wdata[9:5];
                        f_dev     = reg_wdata[4:0];
                        f_pre_off = reg_wdata[10];
                        payload   = 16'hFFFF;
                    end
                end
                REG_DATA: start = 1'b1;
                REG_ADDR: begin
                    if (mode_c45) begin
                        start = 1'b1;
                        kind  = OP_ADDR;
                    end
                end
                default: ;
            endcase
        end
        frame = build_frame(mode_c45, kind, f_port, f_dev, payload);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_c45    <= 1'b0;
            div_q       <= '0;
            addr_busy   <= 1'b0;
            data_busy   <= 1'b0;
            rd_pend     <= 1'b0;
            rd_err      <= 1'b0;
            ctl_dev     <= '0;
            ctl_port    <= '0;
            ctl_pre_off <= 1'b0;
            data_q      <= '0;
            addr_q      <= '0;
        end else begin
            if (eng_done) begin
                addr_busy <= 1'b0;
                data_busy <= 1'b0;
                if (rd_pend) begin
                    data_q <= eng_rdata;
                    rd_err <= eng_fail;
                end
                rd_pend <= 1'b0;
            end
            if (reg_wr_en && !busy_any) begin
                case (reg_addr)
                    REG_CFG: begin
                        mode_c45 <= reg_wdata[6];
                        div_q    <= reg_wdata[8 +: DIV_W];
                    end
                    REG_CTL: begin
                        ctl_dev     <= reg_wdata[4:0];
                        ctl_port    <= reg_wdata[9:5];
                        ctl_pre_off <= reg_wdata[10];
                        if (reg_wdata[15]) begin
                            data_busy <= 1'b1;
                            rd_pend   <= 1'b1;
                            rd_err    <= 1'b0;
                        end
                    end
                    REG_DATA: begin
                        data_q    <= reg_wdata[15:0];
                        data_busy <= 1'b1;
                        rd_err    <= 1'b0;
                    end
                    default: begin
                        addr_q <= reg_wdata[15:0];
                        if (mode_c45) begin
                            addr_busy <= 1'b1;
                            rd_err    <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CFG: begin
                reg_rdata[0]          = addr_busy;
                reg_rdata[1]          = rd_err;
                reg_rdata[6]          = mode_c45;
                reg_rdata[8 +: DIV_W] = div_q;
            end
            REG_CTL: begin
                reg_rdata[4:0] = ctl_dev;
                reg_rdata[9:5] = ctl_port;
                reg_rdata[10]  = ctl_pre_off;
            end
            REG_DATA: begin
                reg_rdata[15:0] = data_q;
                reg_rdata[31]   = data_busy;
            end
            default: reg_rdata[15:0] = addr_q;
        endcase
    end

    mdio_frame_engine #(.DIV_W(DIV_W), .PRE_BITS(PRE_BITS)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (kind),
        .pre_off  (f_pre_off),
        .frame    (frame),
        .half     (div_q),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .mdio_in  (mdio_in),
        .done     (eng_done),
        .rd_data  (eng_rdata),
        .rd_fail  (eng_fail)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        busy_any,
    input logic        reg_wr_en,
    input logic [1:0]  reg_addr,
    input logic [15:0] addr_q,
    input logic [4:0]  ctl_dev,
    input logic [15:0] data_q,
    input logic        rd_err
);

    // R11: the driven value moves only together with an MDC fall
    a_r11_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(mdc) |-> $stable(mdio_out));

    // R1: bus quiet whenever nothing is busy
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_any |-> (mdc && !mdio_oe));

    // R9: MDC only toggles inside a busy frame
    a_r9_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> busy_any);

    // R10: address register untouched by writes while busy
    a_r10_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_any && reg_wr_en && reg_addr == 2'd3) |=> $stable(addr_q));

    // R10: control fields untouched by writes while busy
    a_r10_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_any && reg_wr_en && reg_addr == 2'd1) |=> $stable(ctl_dev));

    // R7: a flagged read error always comes with all-ones data
    a_r7_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (data_q == 16'hFFFF));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .busy_any  (busy_any),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .addr_q    (addr_q),
    .ctl_dev   (ctl_dev),
    .data_q    (data_q),
    .rd_err    (rd_err)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    always #10 clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  mon_en  = 0;
    int  ncap    = 0;
    logic cap_out [64];
    logic cap_oe  [64];
    bit  seen_fall = 0;
    time last_fall, gap_min, gap_max;
    bit  cur_c45 = 0;
    int  cur_div = 0;

    // bus monitor: the PHY samples at every MDC rise
    always @(posedge mdc) begin
        if (mon_en) begin
            if (ncap < 64) begin
                cap_out[ncap] = mdio_out;
                cap_oe[ncap]  = mdio_oe;
            end
            ncap++;
        end
    end

    always @(negedge mdc) begin
        if (mon_en) begin
            if (seen_fall) begin
                if ($time - last_fall < gap_min) gap_min = $time - last_fall;
                if ($time - last_fall > gap_max) gap_max = $time - last_fall;
            end
            seen_fall = 1;
            last_fall = $time;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_free();
        logic [31:0] s, d;
        for (int i = 0; i < 20000; i++) begin
            reg_rd(2'd0, s);
            reg_rd(2'd2, d);
            if (!s[0] && !d[31]) return;
        end
    endtask

    task automatic set_cfg(input bit c45, input int div);
        reg_wr(2'd0, (32'(div) << 8) | (32'(c45) << 6));
        cur_c45 = c45;
        cur_div = div;
    endtask

    // expected frame: kind 0 address, 1 write, 2 read
    function automatic logic [31:0] exp_frame(input bit c45, input int kind,
        input logic [4:0] port, input logic [4:0] dev, input logic [15:0] pl);
        logic [1:0] st, op;
        st = c45 ? 2'b00 : 2'b01;
        if (kind == 0)      op = 2'b00;
        else if (kind == 1) op = 2'b01;
        else                op = c45 ? 2'b11 : 2'b10;
        return {st, op, port, dev, 2'b10, pl};
    endfunction

    task automatic phy_respond(input int pre, input bit answer, input logic [15:0] val);
        for (int k = 0; k < pre + 32; k++) begin
            @(negedge mdc);
            if (answer && k == pre + 15)      mdio_in = 1'b0;
            else if (answer && k >= pre + 16) mdio_in = val[15 - (k - pre - 16)];
            else                              mdio_in = 1'b1;
        end
    endtask

    task automatic run_frame(input int kind, input logic [4:0] port, input logic [4:0] dev,
                             input logic [15:0] pl, input bit pre_off, input bit answer,
                             input bit poke);
        logic [31:0] efr, r;
        int pre, nerr;
        time exp_gap;
        pre = pre_off ? 0 : 32;
        efr = exp_frame(cur_c45, kind, port, dev, pl);
        if (kind == 1) reg_wr(2'd1, (32'(pre_off) << 10) | (32'(port) << 5) | 32'(dev));
        if (kind == 0) reg_wr(2'd1, (32'(pre_off) << 10) | (32'(port) << 5) | 32'(dev));
        ncap = 0; seen_fall = 0; gap_min = 1000000; gap_max = 0; mon_en = 1;
        mdio_in = 1'b1;
        if (kind == 2) begin
            fork
                phy_respond(pre, answer, pl);
            join_none
        end
        if (kind == 0)      reg_wr(2'd3, {16'h0, pl});
        else if (kind == 1) reg_wr(2'd2, {16'h0, pl});
        else reg_wr(2'd1, 32'h8000 | (32'(pre_off) << 10) | (32'(port) << 5) | 32'(dev));
        if (kind == 0) begin
            reg_rd(2'd0, r);
            check(r[0] == 1'b1, "R4", "address busy flag", {31'h0, r[0]}, 32'h1);
        end else begin
            reg_rd(2'd2, r);
            check(r[31] == 1'b1, "R9", "data busy flag", {31'h0, r[31]}, 32'h1);
        end
        if (poke) begin
            reg_wr(2'd2, 32'h0000_DEAD);
            reg_wr(2'd1, 32'h0000_83FF);
            reg_wr(2'd3, 32'h0000_BEEF);
            reg_wr(2'd0, 32'h0000_0F40);
        end
        wait_free();
        mon_en = 0;
        mdio_in = 1'b1;
        // R3 R5 R8: length and bit content
        check(ncap == pre + 32, "R8", "frame length", 32'(ncap), 32'(pre + 32));
        nerr = 0;
        for (int i = 0; i < pre && i < 64; i++)
            if (cap_out[i] !== 1'b1 || cap_oe[i] !== 1'b1) nerr++;
        for (int i = 0; i < 32; i++) begin
            if (pre + i < 64) begin
                if (kind == 2 && i >= 14) begin
                    if (cap_oe[pre + i] !== 1'b0) nerr++;
                end else if (cap_out[pre + i] !== efr[31 - i] || cap_oe[pre + i] !== 1'b1) nerr++;
            end
        end
        check(nerr == 0, (kind == 2) ? "R6" : (cur_c45 ? "R5" : "R3"),
              "frame bits wrong", 32'(nerr), 32'h0);
        exp_gap = 40 * ((cur_div == 0) ? 1 : cur_div);
        check(gap_min == exp_gap && gap_max == exp_gap, "R2", "MDC period ns",
              32'(gap_max), 32'(exp_gap));
        if (kind == 2) begin
            reg_rd(2'd2, r);
            check(r[15:0] == (answer ? pl : 16'hFFFF), answer ? "R6" : "R7", "read data",
                  {16'h0, r[15:0]}, answer ? {16'h0, pl} : 32'hFFFF);
            reg_rd(2'd0, r);
            check(r[1] == !answer, "R7", "read error flag", {31'h0, r[1]}, {31'h0, !answer});
            reg_rd(2'd1, r);
            check(r[15] == 1'b0 && r[9:0] == {port, dev}, "R12", "control readback",
                  r, {22'h0, port, dev});
        end
        if (kind == 1) begin
            reg_rd(2'd2, r);
            check(r == {16'h0, pl}, poke ? "R10" : "R9", "data after write", r, {16'h0, pl});
        end
        if (poke) begin
            reg_rd(2'd3, r);
            check(r[15:0] != 16'hBEEF, "R10", "address changed while busy", r, 32'h0);
            reg_rd(2'd0, r);
            check(r[15:8] == 8'(cur_div), "R10", "divider changed while busy",
                  {24'h0, r[15:8]}, 32'(cur_div));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int nerr;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        nerr = 0;
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), r);
            if (r != 0) nerr++;
        end
        check(nerr == 0, "R1", "registers after reset", 32'(nerr), 32'h0);
        check(mdc === 1'b1 && mdio_oe === 1'b0, "R1", "idle pins", {30'h0, mdc, mdio_oe}, 32'h2);

        // directed: R3 with divider 0, R2 with divider 5
        set_cfg(0, 0);
        run_frame(1, 5'h03, 5'h11, 16'hA5C3, 0, 1, 0);
        set_cfg(0, 5);
        run_frame(1, 5'h1F, 5'h00, 16'h0001, 0, 1, 0);
        // R8 no preamble, R6 C22 read
        set_cfg(0, 2);
        run_frame(1, 5'h0A, 5'h15, 16'h8001, 1, 1, 0);
        run_frame(2, 5'h05, 5'h02, 16'h1234, 0, 1, 0);
        // R7 absent PHY, then cleared by next frame
        run_frame(2, 5'h06, 5'h03, 16'h0000, 0, 0, 0);
        run_frame(1, 5'h06, 5'h03, 16'h4321, 1, 1, 0);
        reg_rd(2'd0, r);
        check(r[1] == 1'b0, "R7", "error flag after next frame", {31'h0, r[1]}, 32'h0);
        // R12 control write without read bit starts nothing
        ncap = 0; mon_en = 1;
        reg_wr(2'd1, 32'h0000_0422);
        repeat (20) @(negedge clk);
        mon_en = 0;
        reg_rd(2'd1, r);
        check(ncap == 0 && r == 32'h0000_0422, "R12", "control store only", r, 32'h422);
        // R4 address write in C22 mode only stores
        ncap = 0; mon_en = 1;
        reg_wr(2'd3, 32'h0000_7777);
        repeat (20) @(negedge clk);
        mon_en = 0;
        reg_rd(2'd3, r);
        check(ncap == 0 && r == 32'h7777, "R4", "C22 address write", r, 32'h7777);
        // R4 / R5 Clause 45 sequence
        set_cfg(1, 1);
        run_frame(0, 5'h02, 5'h01, 16'hC0DE, 0, 1, 0);
        run_frame(1, 5'h02, 5'h01, 16'h5A5A, 0, 1, 0);
        run_frame(2, 5'h02, 5'h07, 16'hF00D, 0, 1, 0);
        // R10 writes while busy are discarded
        set_cfg(0, 3);
        run_frame(1, 5'h09, 5'h04, 16'h2468, 0, 1, 1);

        // random mix
        for (int it = 0; it < 24; it++) begin
            bit c45; int div; int kind;
            c45  = 1'($urandom() % 2);
            div  = int'($urandom() % 4);
            kind = int'($urandom() % 3);
            if (kind == 0 && !c45) kind = 1;
            set_cfg(c45, div);
            run_frame(kind, 5'($urandom()), 5'($urandom()), 16'($urandom()),
                      1'($urandom() % 2), ($urandom() % 4) != 0, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule